// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Controller

This block drives four independent active-high PWM outputs from one source clock. Each channel has an 8-bit prescaler, an 8-bit period modulus and a 16-bit duty compare value. All three are written through a simple single-cycle register bus. A counter step lasts prescale+1 clocks. A period is modulus steps long. The output is high for the first duty steps of each period.

Software writes the prescale, modulus and duty values into staging registers. Writing the duty register arms a commit. When the running period ends, the channel copies the whole staged set into its active set in one step, so no period ever runs on a mix of old and new values. Setting enable starts a new period straight from the staged values. Clearing enable drops the output at once and resets the counters.

Top module: `qpwm_ctrl`

## Requirements
- R1: Channel c occupies the 32-byte block at address c×32, with this layout:
  - offset 0x00: prescale in bits 7:0
  - offset 0x04: modulus in bits 7:0
  - offset 0x08: duty in bits 15:0
  - offset 0x18: enable in bit 0

  A read with req=1 and we=0 returns the last value written to that field, with all other bits zero.
- R2: Offsets other than the four above read as zero. Writes to them change no register and no output.
- R3: After reset every register reads zero and every output is low.
- R4: While a channel is enabled, one step lasts PRE+1 clocks and a period lasts MOD steps. A MOD of 0 counts as a one-step period. The output is high during the first DUTY steps of each period.
- R5: If DUTY ≥ MOD, the output is high for the whole period. If DUTY is 0, the output is always low.
- R6: Writes to prescale, modulus or duty go only to staging and do not alter the running waveform. A duty write arms a commit.
- R7: An armed commit loads the staged prescale, modulus and duty together at the first period boundary after the duty write. The staged values are sampled at that boundary edge.
- R8: When enable goes from 0 to 1, the staged values are loaded directly and clearing any armed commit. The period starts at step 0 one clock after the enable write. If DUTY > 0 the output is high from that clock.
- R9: Writing 0 to enable forces the output low in the cycle in which the enable register clears. The counters are reset.
- R10: Every channel runs independently of the others. Accesses to one channel's block never disturb another channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 7 | Byte address: channel in bits 6:5, offset in bits 4:0 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, valid while a read is requested |
| pwm_o | output | 4 | PWM outputs, one bit per channel |

## Verification
The bench targets modulus and prescale writes that arrive with no duty write. A design that applied them at once would change the period length mid-stream, and the per-clock comparison would catch it.

It also places duty writes close to period boundaries, and disables a channel while its output is high. A commit that swapped values mid-period would leave a truncated period. A disable that waited for the boundary would leave the output high for too long.

It re-enables a channel after changing its duty while disabled. A design that did not load the staged values at enable would show the stale duty.

Finally, it covers:
- DUTY ≥ MOD
- DUTY = 0
- MOD = 0
- writes to unmapped offsets

A wrong compare, a wrong wrap or a stray decode each shows up as a waveform mismatch or a non-zero readback.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int BLK_SHIFT = 5;
  localparam int PRE_W     = 8;
  localparam int MOD_W     = 8;
  localparam int DUTY_W    = 16;
  localparam int DATA_W    = 32;

  localparam logic [BLK_SHIFT-1:0] OFF_PRE  = 5'h00;
  localparam logic [BLK_SHIFT-1:0] OFF_MOD  = 5'h04;
  localparam logic [BLK_SHIFT-1:0] OFF_DUTY = 5'h08;
  localparam logic [BLK_SHIFT-1:0] OFF_EN   = 5'h18;

  typedef struct packed {
    logic [PRE_W-1:0]  pre;
    logic [MOD_W-1:0]  modv;
    logic [DUTY_W-1:0] duty;
  } cfg_t;
endpackage

// File: rtl/qpwm_regfile.sv
module qpwm_regfile
  import qpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output cfg_t [NUM_CH-1:0]     cfg_o,
  output logic [NUM_CH-1:0]     en_o,
  output logic [NUM_CH-1:0]     commit_o
);
  localparam int CH_W = ADDR_W - BLK_SHIFT;

  logic [CH_W-1:0]      sel_ch;
  logic [BLK_SHIFT-1:0] off;
  cfg_t [NUM_CH-1:0]    stg_q;
  logic [NUM_CH-1:0]    en_q;
  logic                 wr;

  assign sel_ch = addr_i[ADDR_W-1:BLK_SHIFT];
  assign off    = addr_i[BLK_SHIFT-1:0];
  assign wr     = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
      en_q  <= '0;
    end else if (wr) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (sel_ch == CH_W'(c)) begin
          case (off)
            OFF_PRE:  stg_q[c].pre  <= wdata_i[PRE_W-1:0];
            OFF_MOD:  stg_q[c].modv <= wdata_i[MOD_W-1:0];
            OFF_DUTY: stg_q[c].duty <= wdata_i[DUTY_W-1:0];
            OFF_EN:   en_q[c]       <= wdata_i[0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    commit_o = '0;
    for (int c = 0; c < NUM_CH; c++)
      commit_o[c] = wr && (sel_ch == CH_W'(c)) && (off == OFF_DUTY);
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (sel_ch == CH_W'(c)) begin
          case (off)
            OFF_PRE:  rdata_o = DATA_W'(stg_q[c].pre);
            OFF_MOD:  rdata_o = DATA_W'(stg_q[c].modv);
            OFF_DUTY: rdata_o = DATA_W'(stg_q[c].duty);
            OFF_EN:   rdata_o = DATA_W'(en_q[c]);
            default:  rdata_o = '0;
          endcase
        end
      end
    end
  end

  assign cfg_o = stg_q;
  assign en_o  = en_q;

  // at most one channel can be committed per access
  assert_single_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(commit_o));
  // a read never produces a commit
  assert_read_no_commit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |-> (commit_o == '0));
endmodule

// File: rtl/qpwm_chan.sv
module qpwm_chan
  import qpwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  cfg_t cfg_i,
  input  logic commit_i,
  output logic pwm_o
);
  cfg_t             act_q;
  logic             run_q;
  logic             pend_q;
  logic [PRE_W-1:0] pcnt_q;
  logic [MOD_W-1:0] scnt_q;
  logic             step_end;
  logic             last_step;
  logic             boundary;

  assign step_end  = (pcnt_q == act_q.pre);
  assign last_step = ({1'b0, scnt_q} + (MOD_W+1)'(1)) >= {1'b0, act_q.modv};
  assign boundary  = run_q && step_end && last_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      pcnt_q <= '0;
      scnt_q <= '0;
    end else if (!en_i) begin
      run_q  <= 1'b0;
      pcnt_q <= '0;
      scnt_q <= '0;
      if (commit_i) pend_q <= 1'b1;
    end else if (!run_q) begin
      // fresh start: staged set goes live directly
      run_q  <= 1'b1;
      act_q  <= cfg_i;
      pcnt_q <= '0;
      scnt_q <= '0;
      pend_q <= commit_i;
    end else begin
      if (step_end) begin
        pcnt_q <= '0;
        if (last_step) begin
          scnt_q <= '0;
          if (pend_q) act_q <= cfg_i;
        end else begin
          scnt_q <= scnt_q + MOD_W'(1);
        end
      end else begin
        pcnt_q <= pcnt_q + PRE_W'(1);
      end
      if (commit_i)      pend_q <= 1'b1;
      else if (boundary) pend_q <= 1'b0;
    end
  end

  // enable gates the output directly so disable takes effect the same cycle
  assign pwm_o = en_i && run_q && ({{(DUTY_W-MOD_W){1'b0}}, scnt_q} < act_q.duty);

  assert_stop_on_disable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!run_q && pcnt_q == '0 && scnt_q == '0));
  assert_prescale_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (pcnt_q <= act_q.pre));
  assert_step_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && act_q.modv != '0) |-> (scnt_q < act_q.modv));
  assert_swap_on_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && !$stable(act_q)) |-> (pcnt_q == '0 && scnt_q == '0));
  assert_fresh_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (pcnt_q == '0 && scnt_q == '0 && act_q == $past(cfg_i)));
  assert_zero_duty_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && act_q.duty == '0) |-> !pwm_o);
endmodule

// File: rtl/qpwm_ctrl.sv
module qpwm_ctrl
  import qpwm_pkg::*;
#(
  parameter  int NUM_CH = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + BLK_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  cfg_t [NUM_CH-1:0] stg_cfg;
  logic [NUM_CH-1:0] en;
  logic [NUM_CH-1:0] commit;

  qpwm_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (bus_req_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .cfg_o    (stg_cfg),
    .en_o     (en),
    .commit_o (commit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    qpwm_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en[g]),
      .cfg_i    (stg_cfg[g]),
      .commit_i (commit[g]),
      .pwm_o    (pwm_o[g])
    );
  end
endmodule

// File: tb/qpwm_ctrl_bench.sv
module qpwm_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [6:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  pwm;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R3";

  always #10 clk = ~clk;

  qpwm_ctrl u_qpwm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  // ---- behavioural reference model ----
  int m_spre[4], m_smod[4], m_sduty[4], m_en[4];
  int m_pend[4], m_run[4], m_apre[4], m_amod[4], m_aduty[4], m_pc[4], m_sc[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_spre[c] = 0; m_smod[c] = 0; m_sduty[c] = 0; m_en[c] = 0;
        m_pend[c] = 0; m_run[c] = 0; m_apre[c] = 0; m_amod[c] = 0;
        m_aduty[c] = 0; m_pc[c] = 0; m_sc[c] = 0;
      end
    end else begin
      int ch, off;
      bit wr;
      ch  = int'(addr) / 32;
      off = int'(addr) % 32;
      wr  = req && we;
      for (int c = 0; c < 4; c++) begin
        bit cm, bnd;
        cm  = wr && ch == c && off == 8;
        bnd = 0;
        if (m_en[c] == 0) begin
          m_run[c] = 0; m_pc[c] = 0; m_sc[c] = 0;
          if (cm) m_pend[c] = 1;
        end else if (m_run[c] == 0) begin
          m_run[c] = 1; m_pc[c] = 0; m_sc[c] = 0;
          m_apre[c] = m_spre[c]; m_amod[c] = m_smod[c]; m_aduty[c] = m_sduty[c];
          m_pend[c] = cm ? 1 : 0;
        end else begin
          if (m_pc[c] == m_apre[c]) begin
            m_pc[c] = 0;
            if (m_sc[c] + 1 >= m_amod[c]) begin
              bnd = 1;
              m_sc[c] = 0;
              if (m_pend[c] != 0) begin
                m_apre[c] = m_spre[c]; m_amod[c] = m_smod[c]; m_aduty[c] = m_sduty[c];
              end
            end else m_sc[c]++;
          end else m_pc[c]++;
          if (cm) m_pend[c] = 1;
          else if (bnd) m_pend[c] = 0;
        end
      end
      if (wr && ch < 4) begin
        case (off)
          0:  m_spre[ch]  = int'(wdata & 32'hFF);
          4:  m_smod[ch]  = int'(wdata & 32'hFF);
          8:  m_sduty[ch] = int'(wdata & 32'hFFFF);
          24: m_en[ch]    = int'(wdata & 32'h1);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [3:0] model_out();
    logic [3:0] v;
    for (int c = 0; c < 4; c++)
      v[c] = (m_en[c] != 0) && (m_run[c] != 0) && (m_sc[c] < m_aduty[c]);
    return v;
  endfunction

  task automatic check(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] e;
      e = model_out();
      check(pwm == e, tag, "per-clock pwm", int'(pwm), int'(e));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    req = 1; we = 1; addr = 7'(a); wdata = 32'(d);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(int a, int exp, string rq);
    @(negedge clk);
    req = 1; we = 0; addr = 7'(a);
    #1;
    check(rdata == 32'(exp), rq, $sformatf("read @%0h", a), int'(rdata), exp);
    req = 0;
  endtask

  task automatic count_high(int ch, int n, output int hits);
    hits = 0;
    repeat (n) begin
      @(negedge clk);
      hits += int'(pwm[ch]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL all watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int h;
    bit [31:0] s;
    rst_n = 0; req = 0; we = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check(pwm == 4'b0, "R3", "pwm in reset", int'(pwm), 0);
    rst_n = 1;
    for (int c = 0; c < 4; c++) begin
      rd(c*32 + 0, 0, "R3"); rd(c*32 + 4, 0, "R3");
      rd(c*32 + 8, 0, "R3"); rd(c*32 + 24, 0, "R3");
    end

    tag = "R4";
    wr(8'h00, 1); wr(8'h04, 4); wr(8'h08, 2); wr(8'h18, 1);
    repeat (20) @(negedge clk);
    count_high(0, 32, h);
    check(h == 16, "R4", "ch0 high clocks per 32", h, 16);

    tag = "R5";
    wr(8'h20, 0); wr(8'h24, 3); wr(8'h28, 5); wr(8'h38, 1);
    wr(8'h40, 2); wr(8'h44, 5); wr(8'h48, 0); wr(8'h58, 1);
    repeat (10) @(negedge clk);
    count_high(1, 20, h);
    check(h == 20, "R5", "duty>=mod stays high", h, 20);
    count_high(2, 20, h);
    check(h == 0, "R5", "zero duty stays low", h, 0);

    tag = "R1";
    rd(8'h00, 1, "R1"); rd(8'h04, 4, "R1"); rd(8'h08, 2, "R1"); rd(8'h18, 1, "R1");
    rd(8'h24, 3, "R1"); rd(8'h48, 0, "R1");
    wr(8'h60, 32'hFFFFFFFF); rd(8'h60, 32'hFF, "R1");
    wr(8'h68, 32'h00012345); rd(8'h68, 32'h2345, "R1");
    wr(8'h78, 32'hFE); rd(8'h78, 0, "R1");

    tag = "R2";
    rd(8'h0C, 0, "R2"); rd(8'h10, 0, "R2"); rd(8'h1C, 0, "R2"); rd(8'h02, 0, "R2");
    wr(8'h0C, 32'hFFFF); wr(8'h14, 32'hFF); wr(8'h1A, 0);
    rd(8'h0C, 0, "R2"); rd(8'h00, 1, "R2"); rd(8'h04, 4, "R2");
    rd(8'h08, 2, "R2"); rd(8'h18, 1, "R2");
    count_high(0, 32, h);
    check(h == 16, "R2", "ch0 waveform after unmapped writes", h, 16);

    tag = "R6";
    wr(8'h04, 6); wr(8'h00, 0);
    repeat (10) @(negedge clk);
    count_high(0, 32, h);
    check(h == 16, "R6", "staged values not yet live", h, 16);

    tag = "R7";
    wr(8'h08, 3);
    repeat (20) @(negedge clk);
    count_high(0, 36, h);
    check(h == 18, "R7", "committed set live", h, 18);

    tag = "R9";
    while (!pwm[0]) @(negedge clk);
    wr(8'h18, 0);
    check(pwm[0] == 1'b0, "R9", "pwm after disable", int'(pwm[0]), 0);
    count_high(0, 10, h);
    check(h == 0, "R9", "stays low while disabled", h, 0);

    tag = "R8";
    wr(8'h08, 1);
    wr(8'h18, 1);
    check(pwm[0] == 1'b0, "R8", "pwm one clock after enable write", int'(pwm[0]), 0);
    count_high(0, 6, h);
    check(h == 1, "R8", "fresh period uses staged duty", h, 1);
    wr(8'h04, 0); wr(8'h08, 1);
    repeat (12) @(negedge clk);
    count_high(0, 10, h);
    check(h == 10, "R4", "mod 0 one-step period", h, 10);

    tag = "R10";
    s = 32'h1234_5678;
    for (int i = 0; i < 1500; i++) begin
      int c, r, v, a;
      s = s * 32'd1103515245 + 32'd12345; c = int'(s[17:16]);
      s = s * 32'd1103515245 + 32'd12345; r = int'(s[18:16]);
      s = s * 32'd1103515245 + 32'd12345; v = int'(s[23:16]);
      case (r)
        0: a = 0;  1: a = 4;  2, 3, 4: a = 8;  5: a = 24;  default: a = 12;
      endcase
      case (a)
        0:  v = v % 3;
        4:  v = v % 7;
        8:  v = v % 8;
        24: v = (v % 8 != 0) ? 1 : 0;
        default: ;
      endcase
      wr(c*32 + a, v);
      repeat (int'(s[26:24])) @(negedge clk);
    end

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule